// File: doc/BRIEF.md
# Streaming row-pipelined Life engine

This block holds a toroidal Game of Life grid and advances it by whole generations. The grid lives in an internal memory with one read and one write per cycle, where each word is one complete row. During a pass the engine reads one row per clock and keeps the last two rows it read in a small window. For every row it computes the next-generation row as a single wide vector and writes it back into the same memory, one row per clock. The first two rows of the pass are kept aside, so the last row and the first row can see their wrapped neighbours after the memory copies have been overwritten.

A host loads the grid through a write port and inspects it through a read port with one cycle of latency, both while the engine is idle. A one-cycle `start` with a generation count in `steps` launches a run. `busy` stays high for the whole run, and a single-cycle `done` marks its end. A 32-bit counter records every completed generation. For each cell, the three cells of each column are first added into a 2-bit column sum. Each column sum is shared by the three cells that sit beside it, and a cell adds the three column sums around it.

Top module: `life_row_engine`

## Requirements
- R1: A dead cell with exactly 3 live cells among its 8 neighbours is alive in the next generation.
- R2: A live cell with 2 or 3 live neighbours is alive in the next generation.
- R3: A cell in any other situation is dead in the next generation, including live cells with fewer than 2 or more than 3 live neighbours.
- R4: The grid wraps as a torus. Row 0 and row H-1 are neighbours, and column 0 and column W-1 are neighbours. Bit j of a row word is column j.
- R5: A start pulse seen while idle runs exactly `steps` generations. With `steps` = 0, `done` is raised on the next cycle and the grid is not changed.
- R6: `busy` rises on the cycle after an accepted start and stays high until the run ends. `done` is high for exactly one cycle, with `busy` low, right after the last generation. A start pulse while busy is ignored.
- R7: `gen_count` increases by exactly one at the end of each completed generation and does not change otherwise.
- R8: Each generation takes H+3 clock cycles. For a run of N generations, `done` is seen N*(H+3) cycles after the first `busy` cycle.
- R9: Host writes presented while `busy` is high have no effect on the grid.
- R10: While the engine is idle, a host write stores `host_wdata` as row `host_waddr`. A row address presented on `host_raddr` returns that row on `host_rdata` after the next clock edge.
- R11: During reset `busy` and `done` are low and `gen_count` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a run when idle |
| steps | input | SW | Number of generations to run |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| gen_count | output | 32 | Completed generations since reset |
| host_we | input | 1 | Host row write enable |
| host_waddr | input | log2(H) | Host write row address |
| host_wdata | input | W | Host write row data |
| host_raddr | input | log2(H) | Host read row address |
| host_rdata | output | W | Row read data, one cycle after the address |

## Verification
A bad row window or bad saved rows corrupt the neighbour counts of the row being written. The grid read back after a single generation then differs from the model, at the wrapped rows 0 and H-1 when the saved rows are wrong. A wrong pass counter or generation counter shows up on the exact cycle of `done` or of the counter step, because `busy`, `done` and `gen_count` are compared with the model on every clock of a run. A host write that leaks into a running pass leaves a stray row that is visible on the first readback.

// File: rtl/life_row_engine.sv
module life_row_engine #(
  parameter int W  = 32,
  parameter int H  = 32,
  parameter int SW = 16
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [SW-1:0]        steps,
  output logic                 busy,
  output logic                 done,
  output logic [31:0]          gen_count,
  input  logic                 host_we,
  input  logic [$clog2(H)-1:0] host_waddr,
  input  logic [W-1:0]         host_wdata,
  input  logic [$clog2(H)-1:0] host_raddr,
  output logic [W-1:0]         host_rdata
);
  localparam int AW = $clog2(H);
  localparam int TW = $clog2(H + 3);
  localparam logic [TW-1:0] T_WRAP = TW'(H + 1);
  localparam logic [TW-1:0] T_LAST = TW'(H + 2);

  logic [W-1:0]  grid [H];
  logic [W-1:0]  rd_q, win_a, win_b, keep0, keep1, row_in, row_nx, wr_data;
  logic [TW-1:0] t, t_m2;
  logic [SW-1:0] left;
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [1:0]    col [W];

  assign row_in     = (t == T_WRAP) ? keep0 : (t == T_LAST) ? keep1 : rd_q;
  assign t_m2       = t - TW'(2);
  assign rd_addr    = (busy && t < TW'(H)) ? t[AW-1:0] : host_raddr;
  assign wr_en      = busy ? (t >= TW'(3)) : host_we;
  assign wr_addr    = busy ? ((t == T_LAST) ? '0 : t_m2[AW-1:0]) : host_waddr;
  assign wr_data    = busy ? row_nx : host_wdata;
  assign host_rdata = rd_q;

  for (genvar j = 0; j < W; j++) begin : g_col
    assign col[j] = {1'b0, win_a[j]} + {1'b0, win_b[j]} + {1'b0, row_in[j]};
  end

  for (genvar j = 0; j < W; j++) begin : g_cell
    localparam int JL = (j + W - 1) % W;
    localparam int JR = (j + 1) % W;
    logic [3:0] n9;
    assign n9        = {2'b0, col[JL]} + {2'b0, col[j]} + {2'b0, col[JR]};
    assign row_nx[j] = (n9 == 4'd3) | (win_b[j] & (n9 == 4'd4));
  end

  always_ff @(posedge clk) begin
    if (wr_en) grid[wr_addr] <= wr_data;
    rd_q <= grid[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      gen_count <= '0;
      t         <= '0;
      left      <= '0;
      win_a     <= '0;
      win_b     <= '0;
      keep0     <= '0;
      keep1     <= '0;
    end else begin
      done  <= 1'b0;
      win_a <= win_b;
      win_b <= row_in;
      if (t == TW'(1)) keep0 <= rd_q;
      if (t == TW'(2)) keep1 <= rd_q;
      if (!busy) begin
        if (start) begin
          if (steps == '0) done <= 1'b1;
          else begin
            busy <= 1'b1;
            left <= steps;
            t    <= '0;
          end
        end
      end else if (t == T_LAST) begin
        gen_count <= gen_count + 32'd1;
        t         <= '0;
        if (left == SW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else left <= left - SW'(1);
      end else t <= t + TW'(1);
    end
  end
endmodule

// File: rtl/life_row_engine_chk.sv
module life_row_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [31:0] gen_count
);
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R6
  AST_GEN_PLUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gen_count) |-> gen_count == $past(gen_count) + 32'd1); // R7
  AST_GEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gen_count) |-> $past(busy)); // R7
  AST_DONE_AFTER_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) || $past(start))); // R5
endmodule

bind life_row_engine life_row_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .gen_count(gen_count)
);

// File: tb/test_life_row_engine.sv
module test_life_row_engine;
  localparam int W = 32;
  localparam int H = 32;
  localparam int SW = 16;
  localparam int AW = $clog2(H);
  localparam int CLK_P = 10;
  localparam int PASS = H + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [SW-1:0] steps = '0;
  logic busy, done;
  logic [31:0] gen_count;
  logic host_we = 1'b0;
  logic [AW-1:0] host_waddr = '0;
  logic [W-1:0] host_wdata = '0;
  logic [AW-1:0] host_raddr = '0;
  logic [W-1:0] host_rdata;

  int nchk = 0;
  int nfail = 0;
  int gen_exp = 0;
  logic [W-1:0] ref_g [H];

  always #(CLK_P/2) clk = ~clk;

  life_row_engine #(.W(W), .H(H), .SW(SW)) i_life_row_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .steps(steps), .busy(busy), .done(done),
    .gen_count(gen_count), .host_we(host_we), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ref_step();
    logic [W-1:0] nx [H];
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++) begin
        int n = 0;
        for (int dr = -1; dr <= 1; dr++)
          for (int dc = -1; dc <= 1; dc++)
            if (dr != 0 || dc != 0) n += int'(ref_g[(r + dr + H) % H][(c + dc + W) % W]);
        nx[r][c] = ref_g[r][c] ? (n == 2 || n == 3) : (n == 3);
      end
    for (int r = 0; r < H; r++) ref_g[r] = nx[r];
  endtask

  task automatic set_cell(input int r, input int c);
    ref_g[(r + H) % H][(c + W) % W] = 1'b1;
  endtask

  task automatic clear_ref();
    for (int r = 0; r < H; r++) ref_g[r] = '0;
  endtask

  task automatic push_all();
    for (int r = 0; r < H; r++) begin
      host_we = 1'b1; host_waddr = AW'(r); host_wdata = ref_g[r];
      @(negedge clk);
    end
    host_we = 1'b0;
  endtask

  task automatic compare_grid(input string tag);
    for (int r = 0; r < H; r++) begin
      host_raddr = AW'(r);
      @(negedge clk);
      chk(host_rdata === ref_g[r], tag, 64'(host_rdata), 64'(ref_g[r]));
    end
  endtask

  task automatic run(input int n, input bit poke);
    int g0 = gen_exp;
    start = 1'b1; steps = SW'(n);
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; cyc <= n * PASS; cyc++) begin
      chk(busy === (cyc < n * PASS), "R6 busy", 64'(busy), 64'(cyc < n * PASS));
      chk(done === (cyc == n * PASS), "R5/R8 done timing", 64'(done), 64'(cyc == n * PASS));
      chk(gen_count === 32'(g0 + cyc / PASS), "R7 gen_count", 64'(gen_count), 64'(g0 + cyc / PASS));
      if (poke && cyc == 2) begin
        host_we = 1'b1; host_waddr = AW'(5); host_wdata = '1;
      end else host_we = 1'b0;
      if (cyc == 4) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
    end
    host_we = 1'b0; start = 1'b0;
    chk(done === 1'b0, "R6 done one cycle", 64'(done), 64'd0);
    for (int i = 0; i < n; i++) ref_step();
    gen_exp += n;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL R8 watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk(busy === 1'b0, "R11 busy in reset", 64'(busy), 64'd0);
    chk(done === 1'b0, "R11 done in reset", 64'(done), 64'd0);
    chk(gen_count === 32'd0, "R11 gen_count in reset", 64'(gen_count), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    clear_ref();
    for (int r = 0; r < H; r++) ref_g[r] = W'(32'h1 << (r % W)) ^ W'(r * 7);
    push_all();
    compare_grid("R10 host write/read");

    clear_ref();
    set_cell(10, 9); set_cell(10, 10); set_cell(10, 11);
    set_cell(20, 20); set_cell(20, 21); set_cell(21, 20); set_cell(21, 21);
    push_all();
    run(1, 1'b0);
    compare_grid("R1/R2/R3 blinker and block");
    run(1, 1'b1);
    compare_grid("R9 write during busy ignored");

    clear_ref();
    set_cell(30, 31); set_cell(31, 32); set_cell(32, 30); set_cell(32, 31); set_cell(32, 32);
    set_cell(15, 0); set_cell(16, 0); set_cell(17, 0);
    push_all();
    run(12, 1'b0);
    compare_grid("R4 glider across wrap");

    run(0, 1'b0);
    compare_grid("R5 zero steps leaves grid");

    for (int s = 0; s < 3; s++) begin
      for (int r = 0; r < H; r++) ref_g[r] = W'($urandom) & W'($urandom | $urandom);
      push_all();
      run(3 + s, 1'b0);
      compare_grid("R1/R2/R3 random seed");
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule